// File: doc/BRIEF.md
# CPU Control Flag Latches

This block holds the small pieces of sequencing state that a microcoded control unit keeps between microinstructions. It stores whether interrupts are inhibited, which of two framebuffers is shown, the level of the interrupt-acknowledge line, and whether a 16-bit address prefix is pending for the current instruction. At the counter-reset that ends each instruction, it decides combinationally whether a pending external interrupt is taken.

A separate path watches the address qualifier. When a 16-bit access begins, the block raises a bus request for a fixed stall and holds the microinstruction counter for that time. All strobes from the microcode decoder are active-low and last one clock. Reset is synchronous and active-high.

Top module: `ctlflag_top`

## Requirements
- R1: The inhibit latch is set by a low `setInhibitN` and cleared by a low `clrInhibitN`. When both are low in the same cycle, the latch ends up clear. Both high leaves it unchanged.
- R2: A low `toggleFbN` inverts `fbSel` at the next clock edge. `fbSelN` is always the complement of `fbSel`.
- R3: A low `toggleAckN` inverts `intAck` at the next clock edge.
- R4: `intTaken` is high in the same cycle only when `ctrReset` and `intReq` are high while the inhibit latch and the prefix latch are both clear.
- R5: A low `setPrefixN` sets the prefix latch. A high `ctrReset` clears it after the interrupt decision of that cycle, which still sees the prefix as set. If both happen in one cycle, the clear wins.
- R6: When `addrQual` is high in a cycle after a cycle in which it was low (or after reset), `busReq` is high during the following cycle for exactly STALL_LEN cycles. `ctrEnable` is low exactly while `busReq` is high.
- R7: Synchronous reset clears every latch: `fbSel`=0, `intAck`=0, `busReq`=0, `ctrEnable`=1, inhibit and prefix clear.
- R8: While `addrQual` stays high, no further stall starts. A new stall starts only after `addrQual` has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clrInhibitN | input | 1 | Clear interrupt inhibit, active low |
| setInhibitN | input | 1 | Set interrupt inhibit, active low |
| toggleFbN | input | 1 | Invert framebuffer select, active low |
| toggleAckN | input | 1 | Invert interrupt acknowledge, active low |
| setPrefixN | input | 1 | Set 16-bit address prefix, active low |
| ctrReset | input | 1 | Microinstruction counter reset (end of instruction) |
| intReq | input | 1 | External interrupt request |
| addrQual | input | 1 | 16-bit access qualifier |
| fbSel | output | 1 | Framebuffer select |
| fbSelN | output | 1 | Complement of framebuffer select |
| intAck | output | 1 | Interrupt acknowledge level |
| intTaken | output | 1 | Interrupt accepted at this counter reset |
| busReq | output | 1 | Bus request during a 16-bit access stall |
| ctrEnable | output | 1 | Microinstruction counter enable |

## Verification
The bench builds the block with the default STALL_LEN of 1, which is the single-tick stall that the control unit expects. With this value, the exact length of the stall can be checked pulse by pulse. It also makes the no-retrigger rule visible when the qualifier is held high for several cycles. The interrupt gate is driven under each combination of the inhibit and prefix latches, including simultaneous set and clear strobes and a prefix set in the same cycle as the counter reset.

// File: rtl/ctlflag_pkg.sv
package ctlflag_pkg;
  // Decoded strobes, active high, passed from control to datapath.
  typedef struct packed {
    logic clrInhibit;
    logic setInhibit;
    logic toggleFb;
    logic toggleAck;
    logic setPrefix;
    logic endInstr;
  } strobe_t;
endpackage

// File: rtl/ctlflag_ctrl.sv
module ctlflag_ctrl
  import ctlflag_pkg::*;
#(
  parameter int STALL_LEN = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clrInhibitN,
  input  logic    setInhibitN,
  input  logic    toggleFbN,
  input  logic    toggleAckN,
  input  logic    setPrefixN,
  input  logic    ctrReset,
  input  logic    addrQual,
  output strobe_t strobes,
  output logic    busReq,
  output logic    ctrEnable
);
  localparam int CW = (STALL_LEN < 2) ? 1 : $clog2(STALL_LEN + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(STALL_LEN);

  logic          qualSeen;
  logic [CW-1:0] stallCnt;
  logic          trigger;

  always_comb begin
    strobes.clrInhibit = ~clrInhibitN;
    strobes.setInhibit = ~setInhibitN;
    strobes.toggleFb   = ~toggleFbN;
    strobes.toggleAck  = ~toggleAckN;
    strobes.setPrefix  = ~setPrefixN;
    strobes.endInstr   = ctrReset;
  end

  // Edge detect: one stall per assertion of the qualifier.
  assign trigger = addrQual & ~qualSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      qualSeen <= 1'b0;
      stallCnt <= '0;
    end else begin
      qualSeen <= addrQual;
      if (trigger)
        stallCnt <= LOAD_VAL;
      else if (stallCnt != '0)
        stallCnt <= stallCnt - 1'b1;
    end
  end

  assign busReq    = (stallCnt != '0);
  assign ctrEnable = ~busReq;
endmodule

// File: rtl/ctlflag_dpath.sv
module ctlflag_dpath
  import ctlflag_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobes,
  input  logic    intReq,
  output logic    fbSel,
  output logic    intAck,
  output logic    intTaken
);
  logic inhibit;
  logic prefix;

  always_ff @(posedge clk) begin
    if (rst) begin
      inhibit <= 1'b0;
      prefix  <= 1'b0;
      fbSel   <= 1'b0;
      intAck  <= 1'b0;
    end else begin
      if (strobes.clrInhibit)      inhibit <= 1'b0;
      else if (strobes.setInhibit) inhibit <= 1'b1;

      if (strobes.endInstr)        prefix <= 1'b0;
      else if (strobes.setPrefix)  prefix <= 1'b1;

      if (strobes.toggleFb)  fbSel  <= ~fbSel;
      if (strobes.toggleAck) intAck <= ~intAck;
    end
  end

  assign intTaken = strobes.endInstr & intReq & ~inhibit & ~prefix;
endmodule

// File: rtl/ctlflag_top.sv
module ctlflag_top
  import ctlflag_pkg::*;
#(
  parameter int STALL_LEN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clrInhibitN,
  input  logic setInhibitN,
  input  logic toggleFbN,
  input  logic toggleAckN,
  input  logic setPrefixN,
  input  logic ctrReset,
  input  logic intReq,
  input  logic addrQual,
  output logic fbSel,
  output logic fbSelN,
  output logic intAck,
  output logic intTaken,
  output logic busReq,
  output logic ctrEnable
);
  strobe_t strobes;

  ctlflag_ctrl #(.STALL_LEN(STALL_LEN)) u_ctrl (
    .clk(clk), .rst(rst),
    .clrInhibitN(clrInhibitN), .setInhibitN(setInhibitN),
    .toggleFbN(toggleFbN), .toggleAckN(toggleAckN),
    .setPrefixN(setPrefixN), .ctrReset(ctrReset), .addrQual(addrQual),
    .strobes(strobes), .busReq(busReq), .ctrEnable(ctrEnable)
  );

  ctlflag_dpath u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .intReq(intReq),
    .fbSel(fbSel), .intAck(intAck), .intTaken(intTaken)
  );

  assign fbSelN = ~fbSel;
endmodule

// File: rtl/ctlflag_checker.sv
module ctlflag_checker #(
  parameter int STALL_LEN = 1
) (
  input logic clk,
  input logic rst,
  input logic toggleFbN,
  input logic toggleAckN,
  input logic ctrReset,
  input logic intReq,
  input logic addrQual,
  input logic fbSel,
  input logic intAck,
  input logic intTaken,
  input logic busReq
);
  p_take_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    intTaken |-> (ctrReset && intReq));

  p_fb_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    !toggleFbN |=> (fbSel != $past(fbSel)));

  p_ack_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    !toggleAckN |=> (intAck != $past(intAck)));

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!fbSel && !intAck && !busReq));

  p_stall_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busReq) |-> $past(addrQual));

  generate
    if (STALL_LEN == 1) begin : g_single
      p_single_tick_r8: assert property (@(posedge clk) disable iff (rst)
        busReq |=> !busReq);
    end
  endgenerate
endmodule

bind ctlflag_top ctlflag_checker #(.STALL_LEN(STALL_LEN)) u_chk (
  .clk(clk), .rst(rst), .toggleFbN(toggleFbN), .toggleAckN(toggleAckN),
  .ctrReset(ctrReset), .intReq(intReq), .addrQual(addrQual),
  .fbSel(fbSel), .intAck(intAck), .intTaken(intTaken), .busReq(busReq)
);

// File: tb/ctlflag_top_bench.sv
module ctlflag_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clrInhibitN = 1'b1, setInhibitN = 1'b1, toggleFbN = 1'b1;
  logic toggleAckN = 1'b1, setPrefixN = 1'b1;
  logic ctrReset = 1'b0, intReq = 1'b0, addrQual = 1'b0;
  logic fbSel, fbSelN, intAck, intTaken, busReq, ctrEnable;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ctlflag_top u_ctlflag_top (
    .clk(clk), .rst(rst),
    .clrInhibitN(clrInhibitN), .setInhibitN(setInhibitN),
    .toggleFbN(toggleFbN), .toggleAckN(toggleAckN), .setPrefixN(setPrefixN),
    .ctrReset(ctrReset), .intReq(intReq), .addrQual(addrQual),
    .fbSel(fbSel), .fbSelN(fbSelN), .intAck(intAck), .intTaken(intTaken),
    .busReq(busReq), .ctrEnable(ctrEnable)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // advance one edge, return to the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    check("R7 fbSel", fbSel, 1'b0);
    check("R7 fbSelN", fbSelN, 1'b1);
    check("R7 intAck", intAck, 1'b0);
    check("R7 busReq", busReq, 1'b0);
    check("R7 ctrEnable", ctrEnable, 1'b1);
    ctrReset = 1'b1; intReq = 1'b1; #1;
    check("R7 latches clear so interrupt taken", intTaken, 1'b1);
    ctrReset = 1'b0; intReq = 1'b0;
    step();
  endtask

  task automatic t_framebuffer();
    toggleFbN = 1'b0; step(); toggleFbN = 1'b1;
    check("R2 fbSel toggled", fbSel, 1'b1);
    check("R2 fbSelN complement", fbSelN, 1'b0);
    step();
    check("R2 idle holds", fbSel, 1'b1);
    toggleFbN = 1'b0; step(); toggleFbN = 1'b1;
    check("R2 toggled back", fbSel, 1'b0);
    check("R2 complement back", fbSelN, 1'b1);
  endtask

  task automatic t_ack();
    toggleAckN = 1'b0; step();
    check("R3 first toggle", intAck, 1'b1);
    step(); toggleAckN = 1'b1;
    check("R3 second toggle", intAck, 1'b0);
    check("R3 fbSel untouched", fbSel, 1'b0);
  endtask

  task automatic t_inhibit();
    intReq = 1'b1;
    ctrReset = 1'b0; #1;
    check("R4 no counter reset", intTaken, 1'b0);
    setInhibitN = 1'b0; step(); setInhibitN = 1'b1;
    ctrReset = 1'b1; #1;
    check("R1 inhibited", intTaken, 1'b0);
    ctrReset = 1'b0;
    clrInhibitN = 1'b0; setInhibitN = 1'b0; step();
    clrInhibitN = 1'b1; setInhibitN = 1'b1;
    ctrReset = 1'b1; #1;
    check("R1 clear wins", intTaken, 1'b1);
    intReq = 1'b0; #1;
    check("R4 no request", intTaken, 1'b0);
    ctrReset = 1'b0;
    step();
  endtask

  task automatic t_prefix();
    intReq = 1'b1;
    setPrefixN = 1'b0; step(); setPrefixN = 1'b1;
    ctrReset = 1'b1; #1;
    check("R5 prefix blocks interrupt", intTaken, 1'b0);
    step();
    #1;
    check("R5 prefix cleared by counter reset", intTaken, 1'b1);
    setPrefixN = 1'b0; step(); setPrefixN = 1'b1; #1;
    check("R5 clear wins over set", intTaken, 1'b1);
    ctrReset = 1'b0; intReq = 1'b0;
    step();
  endtask

  task automatic t_stall();
    addrQual = 1'b1; #1;
    check("R6 no stall same cycle", busReq, 1'b0);
    step();
    check("R6 busReq asserted", busReq, 1'b1);
    check("R6 counter held", ctrEnable, 1'b0);
    step();
    check("R6 single tick", busReq, 1'b0);
    check("R6 counter resumes", ctrEnable, 1'b1);
    step(); step();
    check("R8 no retrigger while high", busReq, 1'b0);
    addrQual = 1'b0; step();
    addrQual = 1'b1; step();
    check("R8 retrigger after low", busReq, 1'b1);
    addrQual = 1'b0; step();
    check("R8 pulse ends", busReq, 1'b0);
  endtask

  task automatic t_mid_reset();
    toggleFbN = 1'b0; step(); toggleFbN = 1'b1;
    check("R2 set before reset", fbSel, 1'b1);
    rst = 1'b1; step(); rst = 1'b0;
    check("R7 reset clears fbSel", fbSel, 1'b0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_framebuffer();
    t_ack();
    t_inhibit();
    t_prefix();
    t_stall();
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule